// File: doc/BRIEF.md
# Split-Word 32x32 Register-Mapped Multiplier

This block is a peripheral multiplier that a 16-bit processor reaches over a simple register bus. Each 32-bit operand is too wide for one bus word, so software writes it as two halves. The low half of the first operand can go to one of two addresses. The address chosen sets the arithmetic mode, signed or unsigned, for the products that follow.

The second operand is loaded the same way. Its low half only stores a value. Writing its high half is the trigger: on that same clock edge the block forms the full 64-bit product from the assembled operands and registers it. Software then reads the product back as four 16-bit words. The operand registers and the mode bit can also be read back.

Read data is registered. The bus address is sampled on a clock edge, and the selected word appears on the read port after that edge. Writes take effect on the edge where the write enable is high.

Top module: `wide_mul_regs`

## Requirements
- R1: After reset, operand 1, operand 2, the product and the read port are zero, and the mode is unsigned (mode bit 0).
- R2: A write to address 0 sets operand 1 to the written 16-bit value with bits 31:16 cleared, and selects unsigned mode.
- R3: A write to address 1 sets operand 1 to the written 16-bit value with bits 31:16 cleared, and selects signed mode.
- R4: A write to address 2 replaces bits 31:16 of operand 1. Bits 15:0 of operand 1 and the mode are kept.
- R5: A write to address 3 sets operand 2 to the written value with bits 31:16 cleared. It leaves the product unchanged.
- R6: A write to address 4 replaces bits 31:16 of operand 2. On the same edge, the 64-bit product of operand 1 and the updated operand 2 is registered. The product is readable from the next cycle onward.
- R7: In signed mode both 32-bit operands are treated as two's complement (sign-extended). In unsigned mode both are zero-extended. The registered product is the low 64 bits of the result.
- R8: Read data is registered: the address sampled on an edge selects what the read port shows after that edge. The read map is as follows:
  - address 8 returns product bits 15:0; address 9 returns bits 31:16; address 10 returns bits 47:32; address 11 returns bits 63:48;
  - address 0 returns operand 1 bits 15:0, and address 2 returns operand 1 bits 31:16;
  - address 3 returns operand 2 bits 15:0, and address 4 returns operand 2 bits 31:16;
  - address 5 returns the mode in bit 0 (1 = signed);
  - every other address returns 0.
- R9: Writes to any address other than 0 to 4 change no operand, mode or product state.
- R10: Only a write to address 4 changes the product; no other write and no idle cycle changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (4) | Register address for both reads and writes |
| bus_wr_en | input | 1 | Write strobe for the current cycle |
| bus_wr_data | input | HALF_W (16) | Write data |
| bus_rd_data | output | HALF_W (16) | Registered read data for the address sampled on the previous edge |

## Verification
A corrupted operand half or mode bit shows up in the product words. It appears two cycles after the triggering write: one edge to register the product and one edge to register the read. The operand readback addresses expose such a fault one cycle after the faulty write, before any multiply runs. A product that changes when it should not shows up as a changed readback word after a non-trigger write. The signed and unsigned corners separate sign-extension faults from plain multiply faults: all-ones operands, the most negative value, and a zero operand.

// File: rtl/wmul_pkg.sv
package wmul_pkg;

  typedef enum logic {
    MODE_UNSIGNED = 1'b0,
    MODE_SIGNED   = 1'b1
  } mul_mode_e;

  // register map (word addresses)
  localparam int unsigned A_OP1_LO_U = 0;
  localparam int unsigned A_OP1_LO_S = 1;
  localparam int unsigned A_OP1_HI   = 2;
  localparam int unsigned A_OP2_LO   = 3;
  localparam int unsigned A_OP2_HI   = 4;
  localparam int unsigned A_MODE     = 5;
  localparam int unsigned A_PROD0    = 8;

endpackage

// File: rtl/wmul_operands.sv
module wmul_operands
  import wmul_pkg::*;
#(
  parameter int unsigned HW = 16,
  parameter int unsigned AW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [HW-1:0]   wr_data,
  output logic [2*HW-1:0] op1_q,
  output logic [HW-1:0]   op2_lo_q,
  output logic [HW-1:0]   op2_hi_q,
  output mul_mode_e       mode_q,
  output logic            start
);

  assign start = wr_en && (wr_addr == AW'(A_OP2_HI));

  always_ff @(posedge clk) begin
    if (rst) begin
      op1_q    <= '0;
      op2_lo_q <= '0;
      op2_hi_q <= '0;
      mode_q   <= MODE_UNSIGNED;
    end else if (wr_en) begin
      case (wr_addr)
        AW'(A_OP1_LO_U): begin
          op1_q  <= {{HW{1'b0}}, wr_data};
          mode_q <= MODE_UNSIGNED;
        end
        AW'(A_OP1_LO_S): begin
          op1_q  <= {{HW{1'b0}}, wr_data};
          mode_q <= MODE_SIGNED;
        end
        AW'(A_OP1_HI): op1_q[2*HW-1:HW] <= wr_data;
        AW'(A_OP2_LO): begin
          op2_lo_q <= wr_data;
          op2_hi_q <= '0;
        end
        AW'(A_OP2_HI): op2_hi_q <= wr_data;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/wmul_engine.sv
module wmul_engine
  import wmul_pkg::*;
#(
  parameter int unsigned OPW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  mul_mode_e        mode,
  input  logic [OPW-1:0]   op_a,
  input  logic [OPW-1:0]   op_b,
  output logic [2*OPW-1:0] prod_q
);

  localparam int unsigned EXT_W  = OPW + 1;
  localparam int unsigned FULL_W = 2 * EXT_W;

  logic               sgn;
  logic signed [EXT_W-1:0]  ext_a, ext_b;
  logic signed [FULL_W-1:0] full;

  assign sgn   = (mode == MODE_SIGNED);
  assign ext_a = {sgn & op_a[OPW-1], op_a};
  assign ext_b = {sgn & op_b[OPW-1], op_b};
  assign full  = ext_a * ext_b;

  always_ff @(posedge clk) begin
    if (rst)        prod_q <= '0;
    else if (start) prod_q <= full[2*OPW-1:0];
  end

endmodule

// File: rtl/wmul_readback.sv
module wmul_readback
  import wmul_pkg::*;
#(
  parameter int unsigned HW = 16,
  parameter int unsigned AW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   addr,
  input  logic [2*HW-1:0] op1,
  input  logic [HW-1:0]   op2_lo,
  input  logic [HW-1:0]   op2_hi,
  input  mul_mode_e       mode,
  input  logic [4*HW-1:0] prod,
  output logic [HW-1:0]   rd_q
);

  localparam int unsigned NW = 4;

  logic [HW-1:0] words [NW];
  logic [HW-1:0] sel;

  for (genvar k = 0; k < NW; k++) begin : g_word
    assign words[k] = prod[k*HW +: HW];
  end

  always_comb begin
    sel = '0;
    case (addr)
      AW'(A_OP1_LO_U): sel = op1[HW-1:0];
      AW'(A_OP1_HI):   sel = op1[2*HW-1:HW];
      AW'(A_OP2_LO):   sel = op2_lo;
      AW'(A_OP2_HI):   sel = op2_hi;
      AW'(A_MODE):     sel = {{(HW-1){1'b0}}, mode == MODE_SIGNED};
      default: ;
    endcase
    for (int k = 0; k < NW; k++) begin
      if (addr == AW'(A_PROD0 + k)) sel = words[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= sel;
  end

endmodule

// File: rtl/wide_mul_regs.sv
module wide_mul_regs
  import wmul_pkg::*;
#(
  parameter int unsigned HALF_W = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [HALF_W-1:0] bus_wr_data,
  output logic [HALF_W-1:0] bus_rd_data
);

  localparam int unsigned OPW = 2 * HALF_W;

  logic [OPW-1:0]    op1_w;
  logic [HALF_W-1:0] op2_lo_w, op2_hi_w;
  mul_mode_e         mode_w;
  logic              start_w;
  logic [2*OPW-1:0]  prod_w;

  wmul_operands #(.HW(HALF_W), .AW(ADDR_W)) u_ops (
    .clk(clk), .rst(rst),
    .wr_en(bus_wr_en), .wr_addr(bus_addr), .wr_data(bus_wr_data),
    .op1_q(op1_w), .op2_lo_q(op2_lo_w), .op2_hi_q(op2_hi_w),
    .mode_q(mode_w), .start(start_w)
  );

  // the trigger write's data forms the upper half of operand 2 this edge
  wmul_engine #(.OPW(OPW)) u_eng (
    .clk(clk), .rst(rst), .start(start_w), .mode(mode_w),
    .op_a(op1_w), .op_b({bus_wr_data, op2_lo_w}), .prod_q(prod_w)
  );

  wmul_readback #(.HW(HALF_W), .AW(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .addr(bus_addr),
    .op1(op1_w), .op2_lo(op2_lo_w), .op2_hi(op2_hi_w),
    .mode(mode_w), .prod(prod_w), .rd_q(bus_rd_data)
  );

endmodule

// File: rtl/wmul_checker.sv
module wmul_checker
  import wmul_pkg::*;
#(
  parameter int unsigned HW = 16,
  parameter int unsigned AW = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [HW-1:0]   wr_data,
  input logic [HW-1:0]   rd_data,
  input logic [2*HW-1:0] op1,
  input mul_mode_e       mode,
  input logic [4*HW-1:0] prod
);

  assert_op1_lo_unsigned_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(A_OP1_LO_U)) |=>
      (op1 == {{HW{1'b0}}, $past(wr_data)} && mode == MODE_UNSIGNED));

  assert_op1_lo_signed_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(A_OP1_LO_S)) |=>
      (op1 == {{HW{1'b0}}, $past(wr_data)} && mode == MODE_SIGNED));

  assert_op1_hi_keeps_low_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(A_OP1_HI)) |=>
      (op1[HW-1:0] == $past(op1[HW-1:0]) && $stable(mode)
       && op1[2*HW-1:HW] == $past(wr_data)));

  assert_prod_only_on_trigger_R10: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == AW'(A_OP2_HI)) |=> $stable(prod));

  assert_read_word0_R8: assert property (@(posedge clk) disable iff (rst)
    (addr == AW'(A_PROD0)) |=> (rd_data == $past(prod[HW-1:0])));

  assert_read_word3_R8: assert property (@(posedge clk) disable iff (rst)
    (addr == AW'(A_PROD0 + 3)) |=> (rd_data == $past(prod[4*HW-1:3*HW])));

endmodule

bind wide_mul_regs wmul_checker #(.HW(HALF_W), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(bus_wr_en), .addr(bus_addr),
  .wr_data(bus_wr_data), .rd_data(bus_rd_data),
  .op1(op1_w), .mode(mode_w), .prod(prod_w)
);

// File: tb/test_wide_mul_regs.sv
module test_wide_mul_regs;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  wide_mul_regs i_wide_mul_regs (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr_en(wr_en),
    .bus_wr_data(wdata), .bus_rd_data(rdata)
  );

  function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b,
                                          input logic sgn);
    logic [63:0] xa, xb;
    xa = sgn ? {{32{a[31]}}, a} : {32'h0, a};
    xb = sgn ? {{32{b[31]}}, b} : {32'h0, b};
    return xa * xb;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic check_prod(input string tag, input logic [63:0] exp);
    logic [15:0] v;
    for (int k = 0; k < 4; k++) begin
      rd(4'(8 + k), v);
      check(tag, v, exp[k*16 +: 16]);
    end
  endtask

  task automatic run_mul(input string tag, input logic [31:0] a, input logic [31:0] b,
                         input logic sgn);
    wr(sgn ? 4'd1 : 4'd0, a[15:0]);
    wr(4'd2, a[31:16]);
    wr(4'd3, b[15:0]);
    wr(4'd4, b[31:16]);
    check_prod(tag, ref_mul(a, b, sgn));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [63:0] last;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 rd_data in reset", rdata, 16'h0);
    rst = 1'b0;
    // R1: all registers zero, mode unsigned
    check_prod("R1 product", 64'h0);
    rd(4'd0, v); check("R1 op1 lo", v, 16'h0);
    rd(4'd4, v); check("R1 op2 hi", v, 16'h0);
    rd(4'd5, v); check("R1 mode", v, 16'h0);

    // R7: corner products
    run_mul("R7 unsigned max", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    run_mul("R7 signed -1*-1", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    run_mul("R7 signed min*min", 32'h8000_0000, 32'h8000_0000, 1'b1);
    run_mul("R7 signed -1*1", 32'hFFFF_FFFF, 32'h0000_0001, 1'b1);
    run_mul("R6 zero operand", 32'h0, 32'h1234_5678, 1'b0);

    // R2 / R3 / R4: op1 halves and mode
    wr(4'd1, 16'hBEEF);
    rd(4'd5, v); check("R3 mode signed", v, 16'h1);
    rd(4'd2, v); check("R3 op1 hi cleared", v, 16'h0);
    wr(4'd2, 16'h8001);
    rd(4'd0, v); check("R4 op1 lo kept", v, 16'hBEEF);
    rd(4'd2, v); check("R4 op1 hi", v, 16'h8001);
    rd(4'd5, v); check("R4 mode kept", v, 16'h1);
    wr(4'd0, 16'h1111);
    rd(4'd5, v); check("R2 mode unsigned", v, 16'h0);
    rd(4'd2, v); check("R2 op1 hi cleared", v, 16'h0);

    // R5: op2 low alone does not multiply
    run_mul("R6 setup", 32'h0003_0005, 32'h0007_000B, 1'b0);
    last = ref_mul(32'h0003_0005, 32'h0007_000B, 1'b0);
    wr(4'd3, 16'h4242);
    check_prod("R5 product unchanged", last);
    rd(4'd3, v); check("R5 op2 lo", v, 16'h4242);
    rd(4'd4, v); check("R5 op2 hi cleared", v, 16'h0);

    // R9: unmapped writes ignored
    wr(4'd6, 16'hFFFF);
    wr(4'd9, 16'hFFFF);
    wr(4'd15, 16'hFFFF);
    check_prod("R9 product", last);
    rd(4'd3, v); check("R9 op2 lo", v, 16'h4242);
    rd(4'd0, v); check("R9 op1 lo", v, 16'h0005);
    rd(4'd7, v); check("R8 unmapped read", v, 16'h0);

    // R6: operand 2 high alone retriggers with kept operands
    wr(4'd4, 16'h0002);
    check_prod("R6 retrigger", ref_mul(32'h0003_0005, 32'h0002_4242, 1'b0));

    // random products in both modes
    for (int i = 0; i < 60; i++) begin
      logic [31:0] a, b;
      logic s;
      a = $urandom; b = $urandom; s = 1'($urandom);
      if (i % 10 == 0) a[31] = 1'b1;
      run_mul(s ? "R7 random signed" : "R6 random unsigned", a, b, s);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule